// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. The sources are two external pins (active low), two timer overflow flags, and one serial port. The serial port raises a request when either its receive flag or its transmit flag is set. Each external pin can be set to one of two sensitivities. In edge mode, a falling edge sets a latched flag. In level mode, the pin requests for as long as its sampled value stays low. The pins are sampled only on a machine-cycle strobe.

An enable byte gates each source separately and also carries a global enable bit. A priority byte places each source at either the high or the low level. Within one level, a fixed polling order decides which source wins. The controller presents one request together with the 8-bit entry address of the winning source.

The core responds with two pulses. An acknowledge pulse marks that level as in service. A return pulse ends the most urgent handler that is still running. A high-level request can interrupt a running low-level handler. A request at the same level or a lower level waits. The controller clears only the latched edge flags. The timer and serial flags belong to their own peripherals and are never cleared here.

Top module: `intc_top`

## Requirements
- R1: After reset, no request is presented and the vector output reads 00h.
- R2: A source can request only when enable bit 7 (global) and its own enable bit are both 1. The own bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R3: The priority byte uses the same bit positions as the enable byte, and a 1 means high level. Any enabled pending high-level source is presented ahead of every low-level source.
- R4: Within one level, the winner follows the fixed order external 0, timer 0, external 1, timer 1, serial, with external 0 first.
- R5: While a request is presented, the vector is 03h for external 0, 0Bh for timer 0, 13h for external 1, 1Bh for timer 1 and 23h for serial. With no request, the vector is 00h.
- R6: The serial source requests when the receive flag, the transmit flag, or both are 1.
- R7: With its type bit at 1 (edge mode), an external source latches a flag when a high sample is followed by a low sample. That flag is cleared when an acknowledge is accepted for that source.
- R8: With its type bit at 0 (level mode), an external source requests while its last sample is low. An acknowledge does not remove this request, so it is presented again after the return pulse.
- R9: The timer and serial requests are not cleared by an acknowledge. They are presented again after the return pulse while they are still set.
- R10: While a low-level handler is in service, a high-level request is presented. Low-level requests are withheld until the return pulse.
- R11: While a high-level handler is in service, no request is presented.
- R12: A return pulse ends the high-level service if one is active. Otherwise it ends the low-level service.
- R13: The external pins are sampled only in cycles where the machine-cycle strobe is 1. A pin change without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | Machine-cycle strobe that samples the external pins |
| ext_pin_n | input | 2 | External interrupt pins, active low (bit 0 = external 0) |
| ext_edge | input | 2 | Type bits: 1 = falling edge, 0 = low level |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| cfg_en | input | 8 | Enable byte (bit 7 global, bits 4..0 per source) |
| cfg_pri | input | 8 | Priority byte (bits 4..0 per source, 1 = high) |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Entry address of the presented source |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core leaves the current handler |

## Verification
The arbitration is tested with several groups of simultaneous sources: one set all at the low level, one mixed across the two levels, and one where only the serial receive or only the serial transmit flag is set. Comparing these cases separates a wrong polling order from a wrong priority mask or a wrong OR of the serial flags.

Each external pin is tested in both sensitivities. Edge mode must stop requesting once its flag is acknowledged, while level mode must request again after the return pulse. This shows whether the flag clear applies only to edge mode.

A preemption sequence puts a low-level timer handler in service and then acknowledges a high-level timer on top of it. The high-level request is kept asserted across the first return pulse. This reveals which in-service level that return actually cleared.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC      = 5;
    localparam int IDX_W     = $clog2(NSRC);
    localparam int VEC_W     = 8;
    localparam int GEN_BIT   = 7;
    localparam int NEXT      = 2;
    localparam logic [VEC_W-1:0] VEC_BASE = 8'h03;
    localparam logic [VEC_W-1:0] VEC_STEP = 8'h08;

    // in-service bits, one per priority level
    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;

    // source index of external input k in the polling order
    function automatic logic [IDX_W-1:0] ext_slot(input int k);
        return IDX_W'(2 * k);
    endfunction
endpackage

// File: rtl/intc_ext_in.sv
module intc_ext_in (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    typedef struct packed {
        logic smp;
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic fall;
        st_d  = st_q;
        fall  = tick && st_q.smp && !pin_n;
        if (tick) st_d.smp = pin_n;
        st_d.flag = edge_mode && (fall || (st_q.flag && !clr));
        req = edge_mode ? st_q.flag : !st_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{smp: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [NEXT-1:0]  ext_edge,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             ser_rx_flag,
    input  logic             ser_tx_flag,
    input  logic [7:0]       cfg_en,
    input  logic [7:0]       cfg_pri,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             irq_ret
);
    svc_t             svc_d, svc_q;
    logic [NEXT-1:0]  ext_req;
    logic [NEXT-1:0]  ext_clr;
    logic [NSRC-1:0]  src, pend, hi_m, lo_m;
    logic             hi_found, lo_found, take_hi, take_lo, grant;
    logic [IDX_W-1:0] hi_idx, lo_idx, sel_idx;

    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        intc_ext_in u_ext (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (cyc_tick),
            .pin_n    (ext_pin_n[k]),
            .edge_mode(ext_edge[k]),
            .clr      (ext_clr[k]),
            .req      (ext_req[k])
        );
        assign ext_clr[k] = grant && (sel_idx == ext_slot(k));
    end

    assign src  = {ser_rx_flag | ser_tx_flag, tmr1_ovf, ext_req[1], tmr0_ovf, ext_req[0]};
    assign pend = src & cfg_en[NSRC-1:0] & {NSRC{cfg_en[GEN_BIT]}};
    assign hi_m = pend & cfg_pri[NSRC-1:0];
    assign lo_m = pend & ~cfg_pri[NSRC-1:0];

    intc_pick #(.N(NSRC), .IW(IDX_W)) u_pick_hi (.mask(hi_m), .found(hi_found), .idx(hi_idx));
    intc_pick #(.N(NSRC), .IW(IDX_W)) u_pick_lo (.mask(lo_m), .found(lo_found), .idx(lo_idx));

    always_comb begin
        take_hi = hi_found && !svc_q.hi;
        take_lo = !take_hi && lo_found && !svc_q.hi && !svc_q.lo;
        sel_idx = take_hi ? hi_idx : lo_idx;
        irq_req = take_hi || take_lo;
        irq_vec = irq_req ? VEC_W'(VEC_BASE + VEC_W'(sel_idx) * VEC_STEP) : '0;
        grant   = irq_ack && irq_req;

        svc_d = svc_q;
        if (irq_ret) begin
            if (svc_q.hi) svc_d.hi = 1'b0;
            else          svc_d.lo = 1'b0;
        end
        if (grant) begin
            if (take_hi) svc_d.hi = 1'b1;
            else         svc_d.lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_en,
    input logic [7:0] cfg_pri,
    input logic       irq_req,
    input logic [7:0] irq_vec,
    input logic       irq_ack,
    input logic       irq_ret
);
    // R2
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en[7] |-> !irq_req);

    // R5
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == 8'h03 || irq_vec == 8'h0B || irq_vec == 8'h13 ||
                     irq_vec == 8'h1B || irq_vec == 8'h23));

    // R5
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_vec == 8'h00);

    // R11
    hi_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !irq_ret && cfg_pri[irq_vec[5:3]]) |=> !irq_req);

    // R2
    src_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> cfg_en[irq_vec[5:3]]);
endmodule

bind intc_top intc_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .cfg_pri(cfg_pri),
    .irq_req(irq_req),
    .irq_vec(irq_vec),
    .irq_ack(irq_ack),
    .irq_ret(irq_ret)
);

// File: tb/intc_tb.sv
module intc_top_tb_top;
    localparam time CLK_PER = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_edge = 2'b00;
    logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
    logic       ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
    logic [7:0] cfg_en = 8'h00, cfg_pri = 8'h00;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0, irq_ret = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PER / 2) clk = ~clk;

    intc_top dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin_n(ext_pin_n),
        .ext_edge(ext_edge), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag), .cfg_en(cfg_en),
        .cfg_pri(cfg_pri), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    // compare request and vector; exp_vec 00h means no request
    task automatic check(input string tag, input logic [7:0] exp_vec);
        logic exp_req;
        exp_req = (exp_vec != 8'h00);
        #1;
        n_run++;
        if (irq_req !== exp_req || irq_vec !== exp_vec) begin
            n_fail++;
            $display("FAIL %s: req=%0b vec=%02h, expected req=%0b vec=%02h",
                     tag, irq_req, irq_vec, exp_req, exp_vec);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic tick_pins(input logic [1:0] pins);
        ext_pin_n = pins; cyc_tick = 1'b1; step(); cyc_tick = 1'b0;
    endtask

    task automatic quiet();
        tmr0_ovf = 0; tmr1_ovf = 0; ser_rx_flag = 0; ser_tx_flag = 0;
        cfg_en = 8'h00; cfg_pri = 8'h00;
        tick_pins(2'b11);
    endtask

    task automatic t_reset();
        check("R1 reset idle", 8'h00);
    endtask

    task automatic t_enable();
        tmr0_ovf = 1; cfg_en = 8'h1F; step();
        check("R2 global off", 8'h00);
        cfg_en = 8'h9D; step();
        check("R2 own bit off", 8'h00);
        cfg_en = 8'h82; step();
        check("R2 enabled timer0 R5", 8'h0B);
        quiet();
    endtask

    task automatic t_order();
        cfg_en = 8'h9F; tmr0_ovf = 1; tmr1_ovf = 1; ser_tx_flag = 1; step();
        check("R4 timer0 first", 8'h0B);
        tmr0_ovf = 0; step();
        check("R4 timer1 next R5", 8'h1B);
        tmr1_ovf = 0; step();
        check("R6 serial tx R5", 8'h23);
        ser_tx_flag = 0; ser_rx_flag = 1; step();
        check("R6 serial rx", 8'h23);
        quiet();
    endtask

    task automatic t_priority();
        cfg_en = 8'h9F; cfg_pri = 8'h10; tmr0_ovf = 1; ser_rx_flag = 1; step();
        check("R3 high serial over low timer0", 8'h23);
        cfg_pri = 8'h02; step();
        check("R3 high timer0", 8'h0B);
        quiet();
    endtask

    task automatic t_edge();
        ext_edge = 2'b01; cfg_en = 8'h81;
        tick_pins(2'b11);
        ext_pin_n = 2'b10; step(); step();
        check("R13 no strobe no sample", 8'h00);
        tick_pins(2'b10);
        check("R7 falling edge latched", 8'h03);
        pulse_ack();
        check("R7 in service", 8'h00);
        pulse_ret();
        check("R7 edge flag cleared by ack", 8'h00);
        ext_edge = 2'b00;
        quiet();
    endtask

    task automatic t_level();
        cfg_en = 8'h84;
        tick_pins(2'b01);
        check("R8 level low requests", 8'h13);
        pulse_ack();
        check("R8 in service", 8'h00);
        pulse_ret();
        check("R8 level kept after return", 8'h13);
        tick_pins(2'b11);
        check("R8 level high releases", 8'h00);
        quiet();
    endtask

    task automatic t_preempt();
        cfg_en = 8'h8A; cfg_pri = 8'h08; tmr0_ovf = 1; step();
        check("R10 low timer0", 8'h0B);
        pulse_ack();
        check("R10 same level waits", 8'h00);
        tmr1_ovf = 1; step();
        check("R10 high preempts", 8'h1B);
        pulse_ack();
        check("R11 high in service blocks all", 8'h00);
        pulse_ret();
        check("R12 return ends high first", 8'h1B);
        tmr1_ovf = 0; step();
        check("R10 low still in service", 8'h00);
        pulse_ret();
        check("R9 timer flag kept R12", 8'h0B);
        quiet();
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable();
        t_order();
        t_priority();
        t_edge();
        t_level();
        t_preempt();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule